// File: doc/BRIEF.md
# Write-Masked Control Register Bank

This block is a small bank of 32-bit configuration registers on a plain register bus (address, write data, write strobe, read strobe, read data). Every write carries its own bit-enable: the upper sixteen bits of the write data select which of the lower sixteen bits are changed. Software can therefore flip one field without first reading the word back. Only the lower half of each control word is stored. The upper half always reads as zero.

Seven control words sit at consecutive word offsets from 0x00. A read-only status word at 0x20 shows two flags coming from an analog interface: calibration finished and delay-locked loop ready. Fixed fields of control word 6 drive the power-up bit, the DLL enable and a drive-strength code. A field of control word 0 drives a bus-clock frequency select. Read data is registered: it appears the cycle after the read strobe and is zero in every other cycle.

Top module: `mask_reg_bank`

## Requirements
- R1: On a write to a control word, stored bit x (0..15) takes write-data bit x only when write-data bit x+16 is 1. Otherwise it keeps its previous value.
- R2: Bits 31:16 of every control word always read back as zero.
- R3: After reset every control bit is zero, so pwrUp, dllEnable, freqSel and driveCode are all 0.
- R4: Control word n (n = 0..6) is at byte offset 4*n. A write to one control word leaves every other control word unchanged.
- R5: A read of offset 0x20 returns calDoneIn in bit 6 and dllReadyIn in bit 5, with all other bits zero.
- R6: The status word is read-only. A write to 0x20 changes no control word and no output.
- R7: Offsets 0x1C, 0x24 and above, and any offset whose two low bits are not 00, are unmapped. Reads of them return zero and writes to them are ignored.
- R8: pwrUp is bit 0 of control word 6 (1 = powered on), dllEnable is bit 1 of word 6, and driveCode is bits 6:4 of word 6 (0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm, 4 = 40 ohm).
- R9: freqSel is bits 13:12 of control word 0 (0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz).
- R10: busRdata holds the addressed word in the cycle after a read strobe and is zero after any cycle without a read strobe.
- R11: When a read and a write to the same control word share a cycle, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data: [31:16] bit-enable, [15:0] value |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| calDoneIn | input | 1 | Calibration-done flag from the analog interface |
| dllReadyIn | input | 1 | DLL-ready flag from the analog interface |
| pwrUp | output | 1 | Power-up control, 1 = powered on |
| dllEnable | output | 1 | DLL enable |
| freqSel | output | 2 | Frequency select code |
| driveCode | output | 3 | Drive-strength code |

## Verification
The hardest case to reach from the ports is a read and a write hitting the same control word in one cycle, because the read value depends on when the register updates. The bench raises both strobes on the same edge with a partial bit-enable. It then checks that the read shows the old value and that a later read shows the merged value. Writes to the status offset and to unmapped offsets are followed by a full read sweep of all seven control words and a check of every output. This shows that nothing else was touched.

// File: rtl/maskbank_pkg.sv
package maskbank_pkg;
  localparam int CTRL_WORDS = 7;
  localparam int IDX_W = $clog2(CTRL_WORDS);

  typedef struct packed {
    logic [CTRL_WORDS-1:0] wrEn;
    logic                  rdCtrl;
    logic                  rdStatus;
    logic [IDX_W-1:0]      rdIdx;
  } bankStrobe_t;
endpackage

// File: rtl/maskbank_decode.sv
module maskbank_decode
  import maskbank_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int StatusWord = 8
) (
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWrite,
  input  logic             busRead,
  output bankStrobe_t      strobe
);
  localparam int WordW = AddrW - 2;

  logic [WordW-1:0] wordIdx;
  logic aligned;
  logic ctrlHit;

  assign wordIdx = busAddr[AddrW-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign ctrlHit = aligned && (wordIdx < WordW'(CTRL_WORDS));

  for (genvar i = 0; i < CTRL_WORDS; i++) begin : g_wr
    assign strobe.wrEn[i] = busWrite && aligned && (wordIdx == WordW'(i));
  end

  assign strobe.rdCtrl   = busRead && ctrlHit;
  assign strobe.rdStatus = busRead && aligned && (wordIdx == WordW'(StatusWord));
  assign strobe.rdIdx    = wordIdx[IDX_W-1:0];
endmodule

// File: rtl/maskbank_store.sv
module maskbank_store
  import maskbank_pkg::*;
#(
  parameter int HalfW = 16,
  parameter int CalDoneBit = 6,
  parameter int DllRdyBit = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [2*HalfW-1:0] busWdata,
  input  logic              calDoneIn,
  input  logic              dllReadyIn,
  output logic [HalfW-1:0]  ctrlLo [CTRL_WORDS],
  output logic [2*HalfW-1:0] busRdata
);
  localparam int FullW = 2 * HalfW;

  logic [HalfW-1:0] wrMask;
  logic [HalfW-1:0] wrVal;
  logic [FullW-1:0] statusWord;

  assign wrMask = busWdata[FullW-1:HalfW];
  assign wrVal  = busWdata[HalfW-1:0];

  for (genvar i = 0; i < CTRL_WORDS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlLo[i] <= '0;
      end else if (strobe.wrEn[i]) begin
        ctrlLo[i] <= (ctrlLo[i] & ~wrMask) | (wrVal & wrMask);
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[CalDoneBit] = calDoneIn;
    statusWord[DllRdyBit]  = dllReadyIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobe.rdCtrl) begin
      busRdata <= {{HalfW{1'b0}}, ctrlLo[strobe.rdIdx]};
    end else if (strobe.rdStatus) begin
      busRdata <= statusWord;
    end else begin
      busRdata <= '0;
    end
  end
endmodule

// File: rtl/mask_reg_bank.sv
module mask_reg_bank
  import maskbank_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int HalfW = 16,
  parameter int StatusWord = 8,
  parameter int PhyWord = 6,
  parameter int ClkWord = 0,
  parameter int PwrBit = 0,
  parameter int DllBit = 1,
  parameter int DriveLsb = 4,
  parameter int DriveW = 3,
  parameter int FreqLsb = 12,
  parameter int FreqW = 2,
  parameter int CalDoneBit = 6,
  parameter int DllRdyBit = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AddrW-1:0]  busAddr,
  input  logic [2*HalfW-1:0] busWdata,
  input  logic              busWrite,
  input  logic              busRead,
  output logic [2*HalfW-1:0] busRdata,
  input  logic              calDoneIn,
  input  logic              dllReadyIn,
  output logic              pwrUp,
  output logic              dllEnable,
  output logic [FreqW-1:0]  freqSel,
  output logic [DriveW-1:0] driveCode
);
  bankStrobe_t strobe;
  logic [HalfW-1:0] ctrlLo [CTRL_WORDS];

  maskbank_decode #(.AddrW(AddrW), .StatusWord(StatusWord)) u_decode (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .busRead (busRead),
    .strobe  (strobe)
  );

  maskbank_store #(.HalfW(HalfW), .CalDoneBit(CalDoneBit), .DllRdyBit(DllRdyBit)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .calDoneIn (calDoneIn),
    .dllReadyIn(dllReadyIn),
    .ctrlLo    (ctrlLo),
    .busRdata  (busRdata)
  );

  assign pwrUp     = ctrlLo[PhyWord][PwrBit];
  assign dllEnable = ctrlLo[PhyWord][DllBit];
  assign driveCode = ctrlLo[PhyWord][DriveLsb +: DriveW];
  assign freqSel   = ctrlLo[ClkWord][FreqLsb +: FreqW];
endmodule

// File: rtl/mask_reg_bank_chk.sv
module mask_reg_bank_chk #(
  parameter int AddrW = 8,
  parameter int HalfW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [AddrW-1:0]  busAddr,
  input logic [2*HalfW-1:0] busWdata,
  input logic              busWrite,
  input logic              busRead,
  input logic [2*HalfW-1:0] busRdata,
  input logic              calDoneIn,
  input logic              dllReadyIn,
  input logic              pwrUp,
  input logic              dllEnable,
  input logic [1:0]        freqSel,
  input logic [2:0]        driveCode
);
  localparam logic [AddrW-1:0] PhyAddr = AddrW'(8'h18);
  localparam logic [AddrW-1:0] StatAddr = AddrW'(8'h20);

  logic ctrlAddr;
  logic unmapped;
  assign ctrlAddr = (busAddr[1:0] == 2'b00) && (busAddr < AddrW'(8'h1C));
  assign unmapped = !ctrlAddr && (busAddr != StatAddr);

  a_r1_masked_hold: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr == PhyAddr && !busWdata[HalfW] |=> $stable(pwrUp));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRead && ctrlAddr |=> busRdata[2*HalfW-1:HalfW] == '0);

  a_r3_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!pwrUp && !dllEnable && freqSel == 2'd0 && driveCode == 3'd0));

  a_r5_status_bits: assert property (@(posedge clk) disable iff (!rstN)
    busRead && busAddr == StatAddr |=>
      busRdata == ((32'($past(calDoneIn)) << 6) | (32'($past(dllReadyIn)) << 5)));

  a_r6_status_ro: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr == StatAddr |=>
      ($stable(pwrUp) && $stable(dllEnable) && $stable(freqSel) && $stable(driveCode)));

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRead && unmapped |=> busRdata == '0);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |=> busRdata == '0);
endmodule

bind mask_reg_bank mask_reg_bank_chk #(.AddrW(AddrW), .HalfW(HalfW)) u_chk (.*);

// File: tb/sim_mask_reg_bank.sv
`timescale 1ns/1ps
module sim_mask_reg_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busWrite = 1'b0;
  logic busRead = 1'b0;
  logic [31:0] busRdata;
  logic calDoneIn = 1'b0;
  logic dllReadyIn = 1'b0;
  logic pwrUp, dllEnable;
  logic [1:0] freqSel;
  logic [2:0] driveCode;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [15:0] model [7];

  always #5 clk = ~clk;

  mask_reg_bank u0 (.*);

  // {write flag, byte offset, write data}
  localparam logic [40:0] VEC [10] = '{
    {1'b1, 8'h00, 32'hFFFF_3000},
    {1'b1, 8'h00, 32'h1000_0000},
    {1'b1, 8'h18, 32'h0073_0031},
    {1'b1, 8'h04, 32'hFFFF_ABCD},
    {1'b1, 8'h08, 32'h00FF_1234},
    {1'b1, 8'h0C, 32'hFF00_5678},
    {1'b1, 8'h10, 32'h0000_FFFF},
    {1'b1, 8'h14, 32'hFFFF_FFFF},
    {1'b1, 8'h04, 32'h000F_0000},
    {1'b1, 8'h18, 32'h0002_0002}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(logic [7:0] a, logic [31:0] d);
    if (a[1:0] == 2'b00 && a < 8'h1C)
      model[a[4:2]] = (model[a[4:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    d = busRdata;
  endtask

  task automatic sweep(string req);
    logic [31:0] rd;
    for (int k = 0; k < 7; k++) begin
      busRd(8'(4 * k), rd);
      check(req, rd, {16'h0, model[k]});
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int k = 0; k < 7; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3: reset state
    check("R3 outputs", {25'h0, pwrUp, dllEnable, freqSel, driveCode}, 32'h0);
    sweep("R3 readback");
    // R10: idle read data is zero
    check("R10 idle", busRdata, 32'h0);

    // vector walk: R1/R2/R4 masked write then readback
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][40]) busWr(VEC[i][39:32], VEC[i][31:0]);
      busRd(VEC[i][39:32], rd);
      check("R1 R2 masked write", rd, {16'h0, model[VEC[i][36:34]]});
      if (i == 1) check("R9 freqSel", 32'(freqSel), 32'd2);
      if (i == 2) check("R8 pwr/drive", {28'h0, driveCode, pwrUp}, {28'h0, 3'd3, 1'b1});
    end
    check("R8 dllEnable", 32'(dllEnable), 32'd1);
    check("R8 driveCode", 32'(driveCode), 32'd3);
    sweep("R4 independence");
    @(negedge clk);
    check("R10 idle after read", busRdata, 32'h0);

    // R5 status flags
    calDoneIn = 1'b1; dllReadyIn = 1'b0;
    busRd(8'h20, rd); check("R5 caldone", rd, 32'h0000_0040);
    calDoneIn = 1'b0; dllReadyIn = 1'b1;
    busRd(8'h20, rd); check("R5 dllready", rd, 32'h0000_0020);
    calDoneIn = 1'b1;
    busRd(8'h20, rd); check("R5 both", rd, 32'h0000_0060);

    // R6 write to status ignored
    busWr(8'h20, 32'hFFFF_0000);
    sweep("R6 status write");
    check("R6 outputs", {25'h0, pwrUp, dllEnable, freqSel, driveCode}, {25'h0, 1'b1, 1'b1, 2'd2, 3'd3});

    // R7 unmapped
    busRd(8'h1C, rd); check("R7 read 0x1C", rd, 32'h0);
    busRd(8'h02, rd); check("R7 read misaligned", rd, 32'h0);
    busRd(8'h40, rd); check("R7 read 0x40", rd, 32'h0);
    busWr(8'h1C, 32'hFFFF_FFFF);
    busWr(8'h19, 32'hFFFF_0000);
    busWr(8'hFC, 32'hFFFF_FFFF);
    sweep("R7 unmapped write");

    // R11 simultaneous read and write
    @(negedge clk);
    busAddr = 8'h14; busWdata = 32'h00F0_0000; busWrite = 1'b1; busRead = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busRead = 1'b0;
    check("R11 old value", busRdata, 32'h0000_FFFF);
    modelWrite(8'h14, 32'h00F0_0000);
    busRd(8'h14, rd); check("R11 merged", rd, 32'h0000_FF0F);

    // R8 power down via masked clear
    busWr(8'h18, 32'h0001_0000);
    check("R8 pwr cleared", {30'h0, pwrUp, dllEnable}, {30'h0, 1'b0, 1'b1});

    // R3 reset again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < 7; k++) model[k] = '0;
    check("R3 outputs after reset", {25'h0, pwrUp, dllEnable, freqSel, driveCode}, 32'h0);
    sweep("R3 readback after reset");

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule